// File: doc/BRIEF.md
# Legacy PC Physical Memory Decoder

This block sits between a CPU-side request port and two byte-wide storage ports, one for main RAM and one for a 256 KB BIOS ROM. A request carries a 32-bit address, a byte count of one to four, a direction flag and up to four bytes of write data. The block clears address bit 20 when the A20 gate is closed. It then works through the request one byte per clock, at ascending addresses. For each byte it decides whether the access goes to RAM, goes to ROM, is dropped, or returns the open-bus value.

The 256 KB window from 0xC0000 to 0xFFFFF is split into sixteen 16 KB segments. Each segment has its own read routing (ROM or shadow RAM) and its own write routing (shadow RAM or inhibited). A small sideband port loads these routings, and a global enable switches the attribute logic on or off. Above installed RAM, reads return 0xFF, except in the top 128 KB of the 4 GB space, where reads alias the ROM. Read bytes are packed little-endian into a 32-bit response that is returned with a one-cycle done pulse.

Both storage arrays are outside the block. The RAM and ROM ports are driven combinationally during the byte cycle, and their read data is expected back in the same cycle.

Top module: `pcmem_decoder`

## Requirements
- R1: When `a20Enable` is 0, bit 20 of `reqAddr` is forced to 0 at acceptance, before any decode; when it is 1 the address is used unchanged.
- R2: Bytes below `RAM_BYTES` and outside 0xC0000–0xFFFFF, including 0x80000–0x9FFFF, read and write RAM at the same address.
- R3: In 0xC0000–0xFFFFF with `attrEnable` = 0, reads return ROM byte `addr[17:0]` and writes leave RAM unchanged.
- R4: With `attrEnable` = 1, a write byte in segment `addr[17:14]` of the window goes into RAM at the same address if that segment's write attribute is 1, and is dropped if it is 0.
- R5: With `attrEnable` = 1, a read byte in the window returns ROM byte `addr[17:0]` if the segment's read attribute is 0, and RAM at the same address if it is 1.
- R6: A window byte whose applicable attribute is 2 or 3 (with `attrEnable` = 1) sets `rspError` in the done cycle, writes nothing, and reads as 0xFF. `rspError` is 0 for requests with no such byte.
- R7: A read byte at an address at or above `RAM_BYTES` returns 0xFF. The exception is an address at or above 0xFFFE0000, which returns ROM byte `addr[17:0]`.
- R8: A write byte at or above `RAM_BYTES` is discarded, while the other bytes of the same request are still written.
- R9: Byte i of a request (i = 0..`reqLenM1`) uses address base+i (modulo 2^32), write data `reqWData[8i+7:8i]`, and read result `rspData[8i+7:8i]`. Unused `rspData` bytes, and all of `rspData` for writes, are 0.
- R10: `reqReady` is 1 only when idle, and a request is accepted on a clock edge with `reqValid` and `reqReady` high. `rspDone` is high for exactly one cycle, following the (`reqLenM1`+1)-th edge after acceptance. `reqReady` is 0 from acceptance until that cycle, in which it is 1 again. No storage port is enabled while `reqReady` is 1.
- R11: After reset all segment attributes are 0. A clock edge with `attrWe` = 1 loads `attrRdIn` and `attrWrIn` into segment `attrSeg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| a20Enable | input | 1 | 1 passes address bit 20, 0 clears it |
| attrEnable | input | 1 | 1 enables per-segment window routing |
| attrWe | input | 1 | Load strobe for one segment's attributes |
| attrSeg | input | 4 | Segment index within the window |
| attrRdIn | input | 2 | Read attribute: 0 ROM, 1 shadow RAM, 2/3 illegal |
| attrWrIn | input | 2 | Write attribute: 0 inhibit, 1 shadow RAM, 2/3 illegal |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept |
| reqAddr | input | 32 | Address of the lowest byte |
| reqLenM1 | input | 2 | Byte count minus one |
| reqWrite | input | 1 | 1 write, 0 read |
| reqWData | input | 32 | Write data, little-endian |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 32 | Assembled read data |
| rspError | output | 1 | An illegal attribute was met |
| ramEn | output | 1 | RAM byte access this cycle |
| ramWe | output | 1 | RAM byte write this cycle |
| ramAddr | output | 32 | RAM byte address |
| ramWData | output | 8 | RAM write byte |
| ramRData | input | 8 | RAM read byte, same cycle |
| romEn | output | 1 | ROM byte access this cycle |
| romAddr | output | 18 | ROM byte offset |
| romRData | input | 8 | ROM read byte, same cycle |

## Verification
A corrupted byte counter or stored length moves the done pulse off its expected cycle. It also puts read bytes into the wrong lanes of `rspData`, and the per-cycle comparison catches this within the first request affected. A wrong attribute entry or a mis-latched base address stays hidden until a byte in the affected segment or address is read back. For that reason the sequence reads back every write, including writes that should have been dropped. The reads also include accesses that straddle segment and RAM-size boundaries, so that a per-request decision made in place of a per-byte one shows up in a single lane.

// File: rtl/pcmem_decoder_pkg.sv
package pcmem_decoder_pkg;
  localparam int BYTE_W    = 8;
  localparam int LANES     = 4;
  localparam int LANE_IDX_W = $clog2(LANES);

  localparam logic [1:0] ATTR_ROM    = 2'd0;
  localparam logic [1:0] ATTR_SHADOW = 2'd1;

  typedef struct packed {
    logic                  load;
    logic                  step;
    logic                  last;
    logic [LANE_IDX_W-1:0] byteIdx;
  } ctrlStrb_t;
endpackage

// File: rtl/pcmem_decoder_ctrl.sv
module pcmem_decoder_ctrl
  import pcmem_decoder_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [LANE_IDX_W-1:0] reqLenM1,
  output logic                  reqReady,
  output logic                  rspDone,
  output ctrlStrb_t             strb
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;

  state_t                state;
  logic [LANE_IDX_W-1:0] byteCnt;
  logic [LANE_IDX_W-1:0] lenM1;

  always_comb begin
    reqReady     = (state == ST_IDLE);
    strb.load    = reqValid && reqReady;
    strb.step    = (state == ST_BUSY);
    strb.last    = (state == ST_BUSY) && (byteCnt == lenM1);
    strb.byteIdx = byteCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
      lenM1   <= '0;
      rspDone <= 1'b0;
    end else begin
      rspDone <= strb.last;
      case (state)
        ST_IDLE: if (strb.load) begin
          state   <= ST_BUSY;
          byteCnt <= '0;
          lenM1   <= reqLenM1;
        end
        ST_BUSY: begin
          if (strb.last) state <= ST_IDLE;
          else           byteCnt <= byteCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcmem_decoder_attr.sv
module pcmem_decoder_attr #(
  parameter int SEG_COUNT = 16,
  localparam int SEG_W    = $clog2(SEG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             attrWe,
  input  logic [SEG_W-1:0] attrSeg,
  input  logic [1:0]       attrRdIn,
  input  logic [1:0]       attrWrIn,
  input  logic [SEG_W-1:0] lookupSeg,
  output logic [1:0]       rdAttr,
  output logic [1:0]       wrAttr
);
  logic [SEG_COUNT-1:0][1:0] rdTab;
  logic [SEG_COUNT-1:0][1:0] wrTab;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdTab <= '0;
      wrTab <= '0;
    end else if (attrWe) begin
      rdTab[attrSeg] <= attrRdIn;
      wrTab[attrSeg] <= attrWrIn;
    end
  end

  assign rdAttr = rdTab[lookupSeg];
  assign wrAttr = wrTab[lookupSeg];
endmodule

// File: rtl/pcmem_decoder_dp.sv
module pcmem_decoder_dp
  import pcmem_decoder_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter longint unsigned RAM_BYTES   = 64'h0020_0000,
  parameter longint unsigned WIN_LO      = 64'h000C_0000,
  parameter longint unsigned WIN_HI      = 64'h000F_FFFF,
  parameter longint unsigned HI_ROM_BASE = 64'hFFFE_0000,
  parameter int              ROM_AW      = 18,
  parameter int              SEG_BYTES   = 16384,
  parameter int              A20_BIT     = 20,
  localparam int             SEG_COUNT   = int'((WIN_HI - WIN_LO + 1) / SEG_BYTES),
  localparam int             SEG_W       = $clog2(SEG_COUNT),
  localparam int             DATA_W      = LANES * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic                a20Enable,
  input  logic                attrEnable,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWData,
  output logic [SEG_W-1:0]    lookupSeg,
  input  logic [1:0]          rdAttr,
  input  logic [1:0]          wrAttr,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspError,
  output logic                ramEn,
  output logic                ramWe,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [BYTE_W-1:0]   ramWData,
  input  logic [BYTE_W-1:0]   ramRData,
  output logic                romEn,
  output logic [ROM_AW-1:0]   romAddr,
  input  logic [BYTE_W-1:0]   romRData
);
  localparam int SEG_SHIFT = $clog2(SEG_BYTES);
  localparam logic [ADDR_W:0]   RAM_LIMIT = (ADDR_W+1)'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] WIN_LO_A  = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] WIN_HI_A  = ADDR_W'(WIN_HI);
  localparam logic [ADDR_W-1:0] HI_ROM_A  = ADDR_W'(HI_ROM_BASE);

  logic [ADDR_W-1:0] baseAddr, gatedAddr, curAddr, segOff;
  logic [DATA_W-1:0] wData, dataReg;
  logic              isWrite, errReg;
  logic              inRam, inWin, inHiRom, byteErr;
  logic [BYTE_W-1:0] rdByte, wByte;

  // A20 gate applied once, at acceptance
  always_comb begin
    gatedAddr          = reqAddr;
    gatedAddr[A20_BIT] = reqAddr[A20_BIT] & a20Enable;
  end

  assign curAddr   = baseAddr + ADDR_W'(strb.byteIdx);
  assign segOff    = curAddr - WIN_LO_A;
  assign lookupSeg = SEG_W'(segOff >> SEG_SHIFT);
  assign inRam     = {1'b0, curAddr} < RAM_LIMIT;
  assign inWin     = (curAddr >= WIN_LO_A) && (curAddr <= WIN_HI_A);
  assign inHiRom   = curAddr >= HI_ROM_A;
  assign wByte     = wData[{strb.byteIdx, 3'b000} +: BYTE_W];

  assign ramAddr  = curAddr;
  assign ramWData = wByte;
  assign romAddr  = curAddr[ROM_AW-1:0];

  // per-byte routing
  always_comb begin
    ramEn   = 1'b0;
    ramWe   = 1'b0;
    romEn   = 1'b0;
    byteErr = 1'b0;
    rdByte  = '1;
    if (strb.step) begin
      if (!inRam) begin
        if (!isWrite && inHiRom) begin
          romEn  = 1'b1;
          rdByte = romRData;
        end
      end else if (inWin) begin
        if (isWrite) begin
          if (attrEnable) begin
            if (wrAttr == ATTR_SHADOW) begin
              ramEn = 1'b1;
              ramWe = 1'b1;
            end else if (wrAttr != ATTR_ROM) begin
              byteErr = 1'b1;
            end
          end
        end else if (!attrEnable || rdAttr == ATTR_ROM) begin
          romEn  = 1'b1;
          rdByte = romRData;
        end else if (rdAttr == ATTR_SHADOW) begin
          ramEn  = 1'b1;
          rdByte = ramRData;
        end else begin
          byteErr = 1'b1;
        end
      end else begin
        ramEn  = 1'b1;
        ramWe  = isWrite;
        rdByte = ramRData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      wData    <= '0;
      isWrite  <= 1'b0;
      dataReg  <= '0;
      errReg   <= 1'b0;
    end else if (strb.load) begin
      baseAddr <= gatedAddr;
      wData    <= reqWData;
      isWrite  <= reqWrite;
      dataReg  <= '0;
      errReg   <= 1'b0;
    end else if (strb.step) begin
      if (!isWrite) dataReg[{strb.byteIdx, 3'b000} +: BYTE_W] <= rdByte;
      if (byteErr) errReg <= 1'b1;
    end
  end

  assign rspData  = dataReg;
  assign rspError = errReg;
endmodule

// File: rtl/pcmem_decoder.sv
module pcmem_decoder
  import pcmem_decoder_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter longint unsigned RAM_BYTES   = 64'h0020_0000,
  parameter longint unsigned WIN_LO      = 64'h000C_0000,
  parameter longint unsigned WIN_HI      = 64'h000F_FFFF,
  parameter longint unsigned HI_ROM_BASE = 64'hFFFE_0000,
  parameter int              ROM_AW      = 18,
  parameter int              SEG_BYTES   = 16384,
  parameter int              A20_BIT     = 20,
  localparam int             SEG_COUNT   = int'((WIN_HI - WIN_LO + 1) / SEG_BYTES),
  localparam int             SEG_W       = $clog2(SEG_COUNT),
  localparam int             DATA_W      = LANES * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  a20Enable,
  input  logic                  attrEnable,
  input  logic                  attrWe,
  input  logic [SEG_W-1:0]      attrSeg,
  input  logic [1:0]            attrRdIn,
  input  logic [1:0]            attrWrIn,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LANE_IDX_W-1:0] reqLenM1,
  input  logic                  reqWrite,
  input  logic [DATA_W-1:0]     reqWData,
  output logic                  rspDone,
  output logic [DATA_W-1:0]     rspData,
  output logic                  rspError,
  output logic                  ramEn,
  output logic                  ramWe,
  output logic [ADDR_W-1:0]     ramAddr,
  output logic [BYTE_W-1:0]     ramWData,
  input  logic [BYTE_W-1:0]     ramRData,
  output logic                  romEn,
  output logic [ROM_AW-1:0]     romAddr,
  input  logic [BYTE_W-1:0]     romRData
);
  ctrlStrb_t        strb;
  logic [SEG_W-1:0] lookupSeg;
  logic [1:0]       rdAttr, wrAttr;

  pcmem_decoder_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLenM1(reqLenM1),
    .reqReady(reqReady), .rspDone(rspDone), .strb(strb)
  );

  pcmem_decoder_attr #(.SEG_COUNT(SEG_COUNT)) u_attr (
    .clk(clk), .rstN(rstN), .attrWe(attrWe), .attrSeg(attrSeg),
    .attrRdIn(attrRdIn), .attrWrIn(attrWrIn), .lookupSeg(lookupSeg),
    .rdAttr(rdAttr), .wrAttr(wrAttr)
  );

  pcmem_decoder_dp #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .HI_ROM_BASE(HI_ROM_BASE), .ROM_AW(ROM_AW), .SEG_BYTES(SEG_BYTES), .A20_BIT(A20_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .a20Enable(a20Enable), .attrEnable(attrEnable),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWData(reqWData),
    .lookupSeg(lookupSeg), .rdAttr(rdAttr), .wrAttr(wrAttr),
    .rspData(rspData), .rspError(rspError),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWData(ramWData), .ramRData(ramRData),
    .romEn(romEn), .romAddr(romAddr), .romRData(romRData)
  );
endmodule

// File: rtl/pcmem_decoder_chk.sv
module pcmem_decoder_chk #(
  parameter int              ADDR_W    = 32,
  parameter longint unsigned RAM_BYTES = 64'h0020_0000,
  parameter longint unsigned WIN_LO    = 64'h000C_0000,
  parameter longint unsigned WIN_HI    = 64'h000F_FFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              attrEnable,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspDone,
  input logic              ramEn,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              romEn
);
  localparam logic [ADDR_W:0]   LIMIT = (ADDR_W+1)'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] WLO   = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] WHI   = ADDR_W'(WIN_HI);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> reqReady); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R10
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!ramEn && !romEn)); // R10
  AST_RAM_IN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ramEn |-> ({1'b0, ramAddr} < LIMIT)); // R8
  AST_WIN_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramAddr >= WLO && ramAddr <= WHI) |-> attrEnable); // R3
  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramEn); // R2
endmodule

bind pcmem_decoder pcmem_decoder_chk #(
  .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .attrEnable(attrEnable), .reqValid(reqValid),
  .reqReady(reqReady), .rspDone(rspDone), .ramEn(ramEn), .ramWe(ramWe),
  .ramAddr(ramAddr), .romEn(romEn)
);

// File: tb/sim_pcmem_decoder.sv
`timescale 1ns/1ps
module sim_pcmem_decoder;
  localparam logic [31:0] RAM_TOP = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        a20Enable = 1'b1, attrEnable = 1'b0, attrWe = 1'b0;
  logic [3:0]  attrSeg = '0;
  logic [1:0]  attrRdIn = '0, attrWrIn = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady, rspDone, rspError;
  logic [31:0] reqAddr = '0, reqWData = '0, rspData;
  logic [1:0]  reqLenM1 = '0;
  logic        ramEn, ramWe, romEn;
  logic [31:0] ramAddr;
  logic [7:0]  ramWData, ramRData, romRData;
  logic [17:0] romAddr;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] ramMem [logic [31:0]];
  logic [7:0] refRam [logic [31:0]];
  logic [1:0] refRd [16];
  logic [1:0] refWr [16];

  always #5 clk = ~clk;

  pcmem_decoder u0 (
    .clk(clk), .rstN(rstN), .a20Enable(a20Enable), .attrEnable(attrEnable),
    .attrWe(attrWe), .attrSeg(attrSeg), .attrRdIn(attrRdIn), .attrWrIn(attrWrIn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqLenM1(reqLenM1),
    .reqWrite(reqWrite), .reqWData(reqWData), .rspDone(rspDone), .rspData(rspData),
    .rspError(rspError), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWData(ramWData), .ramRData(ramRData), .romEn(romEn), .romAddr(romAddr),
    .romRData(romRData)
  );

  function automatic logic [7:0] romFn(logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:16], 6'h15};
  endfunction

  // external storage served by the bench
  always_comb ramRData = ramMem.exists(ramAddr) ? ramMem[ramAddr] : 8'h00;
  always_comb romRData = romFn(romAddr);
  always @(posedge clk) if (ramEn && ramWe) ramMem[ramAddr] = ramWData;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of one byte from the requirements
  task automatic modelByte(logic [31:0] a, bit wr, logic [7:0] wb,
                           output logic [7:0] rb, inout bit err);
    int seg;
    rb = 8'h00;
    if (a >= RAM_TOP) begin                       // R7 / R8
      rb = (a >= 32'hFFFE_0000) ? romFn(a[17:0]) : 8'hFF;
    end else if (a >= 32'h000C_0000 && a <= 32'h000F_FFFF) begin
      seg = int'((a - 32'h000C_0000) >> 14);
      if (wr) begin
        if (attrEnable) begin
          if (refWr[seg] == 2'd1) refRam[a] = wb;  // R4
          else if (refWr[seg] != 2'd0) err = 1;    // R6
        end
      end else if (!attrEnable || refRd[seg] == 2'd0) rb = romFn(a[17:0]); // R3 R5
      else if (refRd[seg] == 2'd1) rb = refRam.exists(a) ? refRam[a] : 8'h00;
      else begin rb = 8'hFF; err = 1; end
    end else begin                                 // R2
      if (wr) refRam[a] = wb;
      else rb = refRam.exists(a) ? refRam[a] : 8'h00;
    end
  endtask

  task automatic doReq(string tag, logic [31:0] addr, int nBytes, bit wr, logic [31:0] wd);
    logic [31:0] base, expData;
    logic [7:0]  rb;
    bit          expErr;
    base = addr;
    if (!a20Enable) base[20] = 1'b0;               // R1
    expData = '0;
    expErr  = 0;
    for (int i = 0; i < nBytes; i++) begin         // R9
      modelByte(base + 32'(i), wr, wd[8*i +: 8], rb, expErr);
      if (!wr) expData[8*i +: 8] = rb;
    end
    @(negedge clk);
    check("R10 ready idle", {31'b0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = addr; reqLenM1 = 2'(nBytes - 1);
    reqWrite = wr;   reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 busy", {31'b0, reqReady}, 32'd0);
    check("R10 no early done", {31'b0, rspDone}, 32'd0);
    for (int k = 1; k <= nBytes; k++) begin
      @(negedge clk);
      if (k < nBytes) begin
        check("R10 done timing", {31'b0, rspDone}, 32'd0);
      end else begin
        check("R10 done pulse", {31'b0, rspDone}, 32'd1);
        check("R10 ready at done", {31'b0, reqReady}, 32'd1);
        check(tag, rspData, expData);
        check("R6 error flag", {31'b0, rspError}, {31'b0, expErr});
      end
    end
    @(negedge clk);
    check("R10 done one cycle", {31'b0, rspDone}, 32'd0);
  endtask

  task automatic setAttr(int seg, logic [1:0] rd, logic [1:0] wr);
    @(negedge clk);
    attrWe = 1'b1; attrSeg = 4'(seg); attrRdIn = rd; attrWrIn = wr;
    @(negedge clk);
    attrWe = 1'b0;
    refRd[seg] = rd; refWr[seg] = wr;              // R11
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin refRd[s] = 2'd0; refWr[s] = 2'd0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R10 reset ready", {31'b0, reqReady}, 32'd1);
    check("R10 reset done", {31'b0, rspDone}, 32'd0);
    check("R10 reset quiet", {30'b0, ramEn, romEn}, 32'd0);

    // R2 / R9 plain RAM, little-endian lanes
    doReq("R9 write4", 32'h0000_1000, 4, 1, 32'hA1B2_C3D4);
    doReq("R9 read4", 32'h0000_1000, 4, 0, 32'h0);
    doReq("R9 read2 offset", 32'h0000_1001, 2, 0, 32'hFFFF_FFFF);
    doReq("R9 read3", 32'h0000_1001, 3, 0, 32'h0);
    doReq("R2 low RAM write", 32'h0008_0000, 3, 1, 32'h0055_6677);
    doReq("R2 low RAM read", 32'h0009_FFFF, 1, 0, 32'h0);
    doReq("R2 low RAM read", 32'h0008_0000, 4, 0, 32'h0);

    // R1 A20 gating
    a20Enable = 1'b0;
    doReq("R1 gated write", 32'h0010_2000, 2, 1, 32'h0000_BEEF);
    a20Enable = 1'b1;
    doReq("R1 alias read", 32'h0000_2000, 2, 0, 32'h0);
    doReq("R1 ungated read", 32'h0010_2000, 2, 0, 32'h0);

    // R3 attribute logic off
    doReq("R3 rom read", 32'h000C_0010, 4, 0, 32'h0);
    doReq("R3 write dropped", 32'h000C_0010, 2, 1, 32'h0000_1234);
    attrEnable = 1'b1;
    setAttr(0, 2'd1, 2'd0);
    doReq("R3 shadow unchanged", 32'h000C_0010, 2, 0, 32'h0);

    // R4 / R5 / R11 per-segment routing
    setAttr(0, 2'd0, 2'd1);
    doReq("R4 shadow write", 32'h000C_3FFE, 4, 1, 32'h1122_3344);
    doReq("R5 rom read seg0", 32'h000C_3FFE, 2, 0, 32'h0);
    setAttr(0, 2'd1, 2'd1);
    doReq("R5 split read", 32'h000C_3FFE, 4, 0, 32'h0);
    setAttr(1, 2'd1, 2'd0);
    doReq("R4 inhibited", 32'h000C_4000, 2, 1, 32'h0000_9999);
    doReq("R4 inhibited readback", 32'h000C_4000, 2, 0, 32'h0);
    doReq("R11 reset attr seg15", 32'h000F_FFFC, 4, 0, 32'h0);
    attrEnable = 1'b0;
    doReq("R3 rom after disable", 32'h000C_3FFE, 4, 0, 32'h0);
    attrEnable = 1'b1;

    // R6 illegal attributes
    setAttr(2, 2'd3, 2'd2);
    doReq("R6 bad write", 32'h000C_8000, 2, 1, 32'h0000_7777);
    doReq("R6 bad read", 32'h000C_8000, 2, 0, 32'h0);
    doReq("R6 clean after", 32'h0000_1000, 1, 0, 32'h0);

    // R7 / R8 RAM size edge and high ROM alias
    doReq("R7 edge read", RAM_TOP - 32'd2, 4, 0, 32'h0);
    doReq("R8 edge write", RAM_TOP - 32'd2, 4, 1, 32'hCAFE_F00D);
    doReq("R8 edge readback", RAM_TOP - 32'd2, 4, 0, 32'h0);
    doReq("R7 open bus", 32'h1234_5678, 4, 0, 32'h0);
    doReq("R7 high rom", 32'hFFFD_FFFE, 4, 0, 32'h0);
    doReq("R7 wrap", 32'hFFFF_FFFE, 4, 0, 32'h0);
    doReq("R8 high write dropped", 32'hFFFF_0000, 2, 1, 32'h0000_AAAA);
    doReq("R7 high rom unchanged", 32'hFFFF_0000, 2, 0, 32'h0);

    finished = 1;
    finishRun();
  end
endmodule